// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block steers the writes of a logic-capture front end into a circular sample memory. Once started, it first fills a programmable pre-trigger history and then keeps overwriting the oldest history, so that only the most recent pre-trigger samples survive while it waits for a trigger. After the trigger it records a programmable number of post-trigger samples and stops. Both depths are configured in whole blocks of 256 samples: a setting `v` asks for `(v+1)*256` samples.

The memory, the trigger evaluation and the readout path sit outside this block. The block only produces the write enable and write address, one cycle after each accepted sample strobe. The caller registers its sample data with the same one-cycle latency. During the post-trigger phase the block reports its progress in completed 256-sample blocks. When capture completes it raises a done flag and presents the address of the oldest retained sample, where readout should begin. Depth settings outside the legal range are clamped when capture starts, so every capture terminates.

A level run control starts a capture when it goes high while the block is idle. Dropping it returns the block to idle from any phase, which ends both an aborted capture and a finished upload.

Top module: `cap_seq_ctrl`

## Requirements
- R1: The window is `W = (pre+post+2)*256` samples, using the clamped depth settings. The first write after a start goes to address 0, each later write goes to the next address, and address `W-1` is followed by address 0.
- R2: After a start, exactly `(pre+1)*256` samples are written before a trigger can be recognised. A trigger that is high during any of these samples, including the last one, is ignored.
- R3: In the waiting phase, a trigger is recognised only in a cycle that also has a sample strobe. That sample is the first post-trigger sample. A trigger without a strobe is ignored.
- R4: Exactly `(post+1)*256` post-trigger samples are written, counting the trigger sample. `done_o` rises together with the write of the last one. While `done_o` is high, no further writes occur, whatever the strobe does.
- R5: `post_blocks_o` is 0 after a start and equals the number of complete 256-sample blocks written since the trigger. It therefore ends at `post+1`.
- R6: When `done_o` is high, `oldest_o` equals `(T - (pre+1)*256) mod W`, where `T` is the address of the trigger sample.
- R7: A depth setting of 0 is treated as 1.
- R8: With `NB = 2^(ADDR_W-BLK_SHIFT)` blocks of memory, the pre setting is limited to `NB-3`. After that, the post setting is limited to `NB-2-pre`, so that `W` never exceeds the memory.
- R9: When `run_i` is low, the next cycle shows no write and `done_o` low. Raising `run_i` again starts a fresh capture at address 0.
- R10: After reset, all outputs are 0. Each write appears on `wr_en_o`/`wr_addr_o` in the cycle after the strobe that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run control: high starts/continues, low returns to idle |
| trig_i | input | 1 | Trigger condition, already evaluated |
| stb_i | input | 1 | Sample strobe; one sample per high cycle |
| pre_depth_i | input | CFG_W | Pre-trigger depth setting, (v+1)*256 samples |
| post_depth_i | input | CFG_W | Post-trigger depth setting, (v+1)*256 samples |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | ADDR_W | Memory write address |
| post_blocks_o | output | ADDR_W-BLK_SHIFT | Complete post-trigger blocks written |
| done_o | output | 1 | Capture complete |
| oldest_o | output | ADDR_W | Address of the oldest retained sample |

## Verification
The bench holds the trigger high through the whole pre-fill, including its last sample. A design that opened the trigger window one sample early would move the trigger address and the oldest-sample address by one. It also waits long enough for the address to wrap inside a window smaller than the memory. A design that wrapped at the memory size instead would write outside the window and report the wrong oldest address.

Sparse strobes, with the trigger pulsed high between them, expose a trigger that is not gated by the strobe. Strobes after completion and after run is dropped expose writes that are not gated by the phase. Oversized and zero depth settings check that the clamps yield a window that fills the memory exactly, or the minimum window.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PREFILL = 3'd1,
    ST_WAIT    = 3'd2,
    ST_POST    = 3'd3,
    ST_DONE    = 3'd4
  } cap_state_e;

endpackage

// File: rtl/cap_depth_clamp.sv
// Clamps the two depth settings to a legal, terminating window.
module cap_depth_clamp #(
  parameter int CFG_W  = 16,
  parameter int NBLK_W = 4
) (
  input  logic [CFG_W-1:0]  pre_i,
  input  logic [CFG_W-1:0]  post_i,
  output logic [NBLK_W-1:0] pre_o,
  output logic [NBLK_W-1:0] post_o
);
  localparam int NB      = 1 << NBLK_W;
  localparam int PRE_MAX = NB - 3;

  logic [CFG_W-1:0] pre_c;
  logic [CFG_W-1:0] post_c;
  logic [CFG_W-1:0] post_max;

  always_comb begin
    pre_c = pre_i;
    if (pre_c == '0)
      pre_c = CFG_W'(1);
    else if (pre_c > CFG_W'(PRE_MAX))
      pre_c = CFG_W'(PRE_MAX);

    post_max = CFG_W'(NB - 2) - pre_c;
    post_c   = post_i;
    if (post_c == '0)
      post_c = CFG_W'(1);
    else if (post_c > post_max)
      post_c = post_max;

    pre_o  = pre_c[NBLK_W-1:0];
    post_o = post_c[NBLK_W-1:0];
  end
endmodule

// File: rtl/cap_ring_ptr.sv
// Write pointer that wraps at a run-time window limit.
module cap_ring_ptr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i)
      ptr_o <= '0;
    else if (adv_i)
      ptr_o <= (ptr_o == last_i) ? '0 : ptr_o + W'(1);
  end
endmodule

// File: rtl/cap_seq_ctrl.sv
module cap_seq_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int BLK_SHIFT = 8,
  parameter int CFG_W     = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        run_i,
  input  logic                        trig_i,
  input  logic                        stb_i,
  input  logic [CFG_W-1:0]            pre_depth_i,
  input  logic [CFG_W-1:0]            post_depth_i,
  output logic                        wr_en_o,
  output logic [ADDR_W-1:0]           wr_addr_o,
  output logic [ADDR_W-BLK_SHIFT-1:0] post_blocks_o,
  output logic                        done_o,
  output logic [ADDR_W-1:0]           oldest_o
);
  import cap_seq_pkg::*;

  localparam int NBLK_W = ADDR_W - BLK_SHIFT;
  localparam int CNT_W  = ADDR_W + 1;

  cap_state_e          state_q;
  logic [NBLK_W-1:0]   pre_c, post_c;
  logic [CNT_W-1:0]    pre_samp_c, post_samp_c;
  logic [CNT_W-1:0]    pre_samp_q, post_samp_q;
  logic [ADDR_W-1:0]   win_last_c, win_last_q;
  logic [CNT_W-1:0]    cnt_q, cnt_nxt;
  logic [ADDR_W-1:0]   ptr;
  logic [CNT_W-1:0]    ptr_ext, oldest_c;
  logic                active, adv;

  cap_depth_clamp #(.CFG_W(CFG_W), .NBLK_W(NBLK_W)) i_clamp (
    .pre_i  (pre_depth_i),
    .post_i (post_depth_i),
    .pre_o  (pre_c),
    .post_o (post_c)
  );

  assign pre_samp_c  = (CNT_W'(pre_c) + CNT_W'(1)) << BLK_SHIFT;
  assign post_samp_c = (CNT_W'(post_c) + CNT_W'(1)) << BLK_SHIFT;
  assign win_last_c  = ADDR_W'(pre_samp_c + post_samp_c - CNT_W'(1));

  assign active = (state_q == ST_PREFILL) || (state_q == ST_WAIT) || (state_q == ST_POST);
  assign adv    = run_i && stb_i && active;

  cap_ring_ptr #(.W(ADDR_W)) i_ptr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (state_q == ST_IDLE),
    .adv_i  (adv),
    .last_i (win_last_q),
    .ptr_o  (ptr)
  );

  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign ptr_ext  = CNT_W'(ptr);
  assign oldest_c = (ptr_ext >= pre_samp_q) ? (ptr_ext - pre_samp_q)
                  : (ptr_ext + CNT_W'(win_last_q) + CNT_W'(1) - pre_samp_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q       <= ST_IDLE;
      pre_samp_q    <= '0;
      post_samp_q   <= '0;
      win_last_q    <= '0;
      cnt_q         <= '0;
      wr_en_o       <= 1'b0;
      wr_addr_o     <= '0;
      post_blocks_o <= '0;
      done_o        <= 1'b0;
      oldest_o      <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (!run_i) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b0;
      end else begin
        if (adv) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= ptr;
        end
        case (state_q)
          ST_IDLE: begin
            pre_samp_q    <= pre_samp_c;
            post_samp_q   <= post_samp_c;
            win_last_q    <= win_last_c;
            cnt_q         <= '0;
            post_blocks_o <= '0;
            oldest_o      <= '0;
            done_o        <= 1'b0;
            state_q       <= ST_PREFILL;
          end
          ST_PREFILL: begin
            if (stb_i) begin
              if (cnt_nxt == pre_samp_q) begin
                cnt_q   <= '0;
                state_q <= ST_WAIT;
              end else begin
                cnt_q <= cnt_nxt;
              end
            end
          end
          ST_WAIT: begin
            if (stb_i && trig_i) begin
              oldest_o <= oldest_c[ADDR_W-1:0];
              cnt_q    <= CNT_W'(1);
              state_q  <= ST_POST;
            end
          end
          ST_POST: begin
            if (stb_i) begin
              cnt_q <= cnt_nxt;
              if (cnt_nxt[BLK_SHIFT-1:0] == '0)
                post_blocks_o <= post_blocks_o + NBLK_W'(1);
              if (cnt_nxt == post_samp_q) begin
                done_o  <= 1'b1;
                state_q <= ST_DONE;
              end
            end
          end
          ST_DONE: ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cap_seq_chk.sv
module cap_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int NBLK_W = 4
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              run_i,
  input logic              stb_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              done_o,
  input logic [NBLK_W-1:0] post_blocks_o,
  input logic [ADDR_W-1:0] win_last_q
);
  // R1
  addr_in_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_o |-> wr_addr_o <= win_last_q);

  // R4
  no_write_after_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && $past(done_o)) |-> !wr_en_o);

  // R4
  done_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && run_i) |=> done_o);

  // R9
  stop_on_run_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> (!wr_en_o && !done_o));

  // R5
  blocks_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (post_blocks_o != $past(post_blocks_o)) |->
      (post_blocks_o == $past(post_blocks_o) + NBLK_W'(1) || post_blocks_o == '0));

  // R10
  write_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_o |-> ($past(stb_i) && $past(run_i)));
endmodule

bind cap_seq_ctrl cap_seq_chk #(
  .ADDR_W (ADDR_W),
  .NBLK_W (ADDR_W - BLK_SHIFT)
) i_cap_seq_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .run_i         (run_i),
  .stb_i         (stb_i),
  .wr_en_o       (wr_en_o),
  .wr_addr_o     (wr_addr_o),
  .done_o        (done_o),
  .post_blocks_o (post_blocks_o),
  .win_last_q    (win_last_q)
);

// File: tb/test_cap_seq_ctrl.sv
`timescale 1ns/1ps
module test_cap_seq_ctrl;
  localparam int ADDR_W    = 12;
  localparam int BLK_SHIFT = 8;
  localparam int CFG_W     = 16;
  localparam int BLK       = 1 << BLK_SHIFT;
  localparam int NB        = 1 << (ADDR_W - BLK_SHIFT);

  logic                        clk = 1'b0;
  logic                        rst = 1'b1;
  logic                        run = 1'b0;
  logic                        trig = 1'b0;
  logic                        stb = 1'b0;
  logic [CFG_W-1:0]            pre_d = '0;
  logic [CFG_W-1:0]            post_d = '0;
  logic                        wr_en;
  logic [ADDR_W-1:0]           wr_addr;
  logic [ADDR_W-BLK_SHIFT-1:0] post_blocks;
  logic                        done;
  logic [ADDR_W-1:0]           oldest;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int g;
  int win;
  bit sparse_mode;

  always #2 clk = ~clk;

  cap_seq_ctrl #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .CFG_W(CFG_W)) i_cap_seq_ctrl (
    .clk_i(clk), .rst_i(rst), .run_i(run), .trig_i(trig), .stb_i(stb),
    .pre_depth_i(pre_d), .post_depth_i(post_d),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .post_blocks_o(post_blocks),
    .done_o(done), .oldest_o(oldest)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: every write is compared against the scoreboard queue (R1, R10).
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R9 unexpected write", int'(wr_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(wr_addr) == e, "R1 write address", int'(wr_addr), e);
      end
    end
  end

  // Called at a negedge; returns at the negedge after the sample is visible.
  task automatic push_sample(input bit t);
    stb  = 1'b1;
    trig = t;
    exp_q.push_back(g % win);
    g++;
    @(negedge clk);
    if (sparse_mode) begin
      stb  = 1'b0;
      trig = 1'b1;   // R3: trigger without strobe must be ignored
      @(negedge clk);
    end
    stb  = 1'b0;
    trig = 1'b0;
  endtask

  task automatic run_capture(input int pre_cfg, input int post_cfg, input int waitn,
                             input bit early, input bit sparse);
    int pc, qc, qm, p_s, q_s, ta, exp_old;
    pc = (pre_cfg < 1) ? 1 : ((pre_cfg > NB - 3) ? NB - 3 : pre_cfg);      // R7, R8
    qm = NB - 2 - pc;
    qc = (post_cfg < 1) ? 1 : ((post_cfg > qm) ? qm : post_cfg);
    p_s = (pc + 1) * BLK;
    q_s = (qc + 1) * BLK;
    win = p_s + q_s;
    sparse_mode = sparse;
    g = 0;
    @(negedge clk);
    pre_d  = CFG_W'(pre_cfg);
    post_d = CFG_W'(post_cfg);
    run    = 1'b1;
    @(negedge clk);
    chk(post_blocks == 0, "R5 blocks cleared at start", int'(post_blocks), 0);
    // R2: pre-fill, trigger optionally held high throughout
    for (int i = 0; i < p_s; i++) push_sample(early);
    for (int i = 0; i < waitn; i++) push_sample(1'b0);
    ta = g % win;
    push_sample(1'b1);
    for (int j = 1; j < q_s; j++) begin
      if (j % BLK == 0)
        chk(int'(post_blocks) == j / BLK, "R5 block progress", int'(post_blocks), j / BLK);
      chk(done == 1'b0, "R4 done not early", int'(done), 0);
      push_sample(j[0]);
    end
    chk(done == 1'b1, "R4 done with last write", int'(done), 1);
    chk(int'(post_blocks) == qc + 1, "R5 final blocks", int'(post_blocks), qc + 1);
    exp_old = (ta - p_s + win) % win;
    chk(int'(oldest) == exp_old, "R6 oldest address", int'(oldest), exp_old);
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    // R4: strobes after done must not write
    sparse_mode = 1'b0;
    for (int i = 0; i < 4; i++) begin
      stb = 1'b1; trig = 1'b1;
      @(negedge clk);
    end
    stb = 1'b0; trig = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R4 done held", int'(done), 1);
    chk(wr_en == 1'b0, "R4 no write after done", int'(wr_en), 0);
    run = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done cleared", int'(done), 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(wr_en == 1'b0, "R10 reset wr_en", int'(wr_en), 0);
    chk(done == 1'b0, "R10 reset done", int'(done), 0);
    chk(post_blocks == 0, "R10 reset blocks", int'(post_blocks), 0);
    chk(oldest == 0, "R10 reset oldest", int'(oldest), 0);
    rst = 1'b0;
    @(negedge clk);

    run_capture(1, 1, 100, 1'b0, 1'b0);      // R1 basic
    run_capture(0, 0, 700, 1'b1, 1'b0);      // R7 clamp to min, R1 wrap
    run_capture(20, 20, 0, 1'b1, 1'b0);      // R8 clamp, R2 early trigger held
    run_capture(2, 3, 300, 1'b1, 1'b1);      // R3 sparse strobes

    // R9: abort mid pre-fill, then restart from address 0
    win = 1024; g = 0; sparse_mode = 1'b0;
    pre_d = 16'd1; post_d = 16'd1; run = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 100; i++) push_sample(1'b1);
    run = 1'b0; stb = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk(wr_en == 1'b0, "R9 no write while stopped", int'(wr_en), 0);
      @(negedge clk);
    end
    stb = 1'b0;
    chk(exp_q.size() == 0, "R9 abort writes", exp_q.size(), 0);
    run_capture(1, 2, 5, 1'b0, 1'b0);        // R9 restart at address 0

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule